// File: doc/BRIEF.md
# Shared-Timebase Compare/Capture Array

This block is a peripheral counter array: a single free-running 16-bit time base is shared by five identical channels. Each channel holds a 16-bit compare/capture register and owns one external pin. A channel can sit idle, capture the time base on pin edges, flag a compare match, toggle its pin on a match, or produce an 8-bit pulse-width output. The last channel can also act as a watchdog that issues a reset request.

The time base advances from one of four sources: every second clock, every fourth clock, a one-cycle tick from a neighbouring timer, or the rising edge of an external clock pin. A run input gates counting. Software reaches the block through a byte-wide write port that addresses the time base, each channel's compare bytes and each channel's mode. Event flags and the overflow flag are sticky and are cleared through dedicated strobes. The current count and every channel register are brought out for reading.

Top module: `tca_top`

## Requirements
- R1: After reset the count, every channel register and mode, every pin output, every event flag, the overflow flag and the reset request are zero.
- R2: Source select 0 advances the count once every 2 clocks, 1 once every 4 clocks, 2 once per clock in which the tick input is high, and 3 once per rising edge of the external clock pin after a two-flop synchronizer.
- R3: With run low the count does not advance and the clock divider restarts from zero.
- R4: A step from 16'hFFFF to 0 sets the overflow flag; the flag stays set until the clear strobe, and a wrap in the same cycle as a clear leaves it set.
- R5: Modes 1, 2 and 3 capture the count into the channel register on a synchronized rising edge, falling edge, or either edge respectively, and set the channel's event flag; an edge of the other polarity leaves the register and flag untouched; the pin output stays low.
- R6: Mode 4 sets the event flag when the count steps onto the compare value; the pin output stays low; a count that equals the compare value without stepping onto it raises nothing.
- R7: Mode 5 inverts the pin output and sets the event flag each time the count steps onto the compare value.
- R8: Mode 6 drives the pin high while the count's low byte is below the compare low byte and low otherwise, equality included.
- R9: In mode 6, when the count's low byte wraps from 8'hFF to 0, the compare high byte is copied into the compare low byte.
- R10: Mode 7 on channel 4 raises the reset request for exactly one clock when the count steps onto the compare value, without setting the event flag; mode 7 on any other channel does nothing; rewriting the compare value before the match avoids the request.
- R11: Writes select their target by code: 0 count low byte, 1 count high byte, 2 compare low byte, 3 compare high byte, 4 mode (data bits 2:0); the channel index picks the channel.
- R12: A channel event flag stays set until its clear strobe bit is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Counting enable |
| clk_src | input | 2 | Time-base source code |
| ext_clk | input | 1 | External count pin |
| t0_tick | input | 1 | One-cycle tick from a neighbouring timer |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target code |
| wr_idx | input | 3 | Channel index for channel writes |
| wr_data | input | 8 | Write data byte |
| evt_clr | input | 5 | Per-channel event flag clear |
| ovf_clr | input | 1 | Overflow flag clear |
| pin_in | input | 5 | Channel pin inputs |
| pin_out | output | 5 | Channel pin outputs |
| evt_flag | output | 5 | Per-channel sticky event flags |
| ovf_flag | output | 1 | Sticky time-base overflow flag |
| wdt_rst | output | 1 | One-cycle watchdog reset request |
| tb_value | output | 16 | Current count |
| mod_reg | output | 80 | Channel registers, channel i at bits 16*i+15:16*i |

## Verification
The awkward cases are the ones tied to a particular count value at a particular moment: a compare hit exactly on a byte wrap, a count loaded equal to the compare value without stepping onto it, and the duty reload as the low byte rolls over. The stimulus reaches them deterministically by selecting the tick source and stepping the count one tick at a time after loading it through the write port, so each hit lands on a known cycle. Capture is tested with counting stopped so the latched value is known regardless of synchronizer delay.

// File: rtl/tca_pkg.sv
package tca_pkg;
    typedef enum logic [1:0] {
        SRC_DIV2 = 2'd0,
        SRC_DIV4 = 2'd1,
        SRC_T0   = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        MD_OFF      = 3'd0,
        MD_CAP_RISE = 3'd1,
        MD_CAP_FALL = 3'd2,
        MD_CAP_BOTH = 3'd3,
        MD_TIMER    = 3'd4,
        MD_TOGGLE   = 3'd5,
        MD_PWM      = 3'd6,
        MD_WDOG     = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        WR_TB_LO  = 3'd0,
        WR_TB_HI  = 3'd1,
        WR_CMP_LO = 3'd2,
        WR_CMP_HI = 3'd3,
        WR_MODE   = 3'd4
    } wsel_e;
endpackage

// File: rtl/tca_timebase.sv
module tca_timebase
    import tca_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [1:0]    src_sel,
    input  logic          ext_clk,
    input  logic          t0_tick,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [7:0]    wr_data,
    input  logic          ovf_clr,
    output logic [CW-1:0] count,
    output logic          step,
    output logic          lo_wrap,
    output logic          ovf_flag
);
    localparam int HW = CW - 8;

    typedef struct packed {
        logic [CW-1:0] count;
        logic [1:0]    pre;
        logic          ext_s1;
        logic          ext_s2;
        logic          ext_prev;
        logic          step;
        logic          lo_wrap;
        logic          ovf;
    } tb_state_t;

    tb_state_t q, d;
    logic      tick;

    always_comb begin
        d          = q;
        d.ext_s1   = ext_clk;
        d.ext_s2   = q.ext_s1;
        d.ext_prev = q.ext_s2;
        unique case (src_e'(src_sel))
            SRC_DIV2: tick = q.pre[0];
            SRC_DIV4: tick = &q.pre;
            SRC_T0:   tick = t0_tick;
            SRC_EXT:  tick = q.ext_s2 & ~q.ext_prev;
            default:  tick = 1'b0;
        endcase
        tick      = tick & run_en;
        d.pre     = run_en ? q.pre + 2'd1 : 2'd0;
        d.step    = 1'b0;
        d.lo_wrap = 1'b0;
        if (tick) begin
            d.count   = q.count + 1'b1;
            d.lo_wrap = &q.count[7:0];
        end
        if (ovf_clr)
            d.ovf = 1'b0;
        if (tick && (&q.count))
            d.ovf = 1'b1;
        if (wr_lo)
            d.count[7:0] = wr_data;
        if (wr_hi)
            d.count[CW-1:8] = HW'(wr_data);
        d.step = tick & ~wr_lo & ~wr_hi;
        if (wr_lo || wr_hi)
            d.lo_wrap = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.count;
    assign step     = q.step;
    assign lo_wrap  = q.lo_wrap;
    assign ovf_flag = q.ovf;

    // R3: stopped and unwritten count holds its value
    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_lo && !wr_hi) |=> $stable(count));

    // R4: wrap from all-ones sets the overflow flag
    p_wrap_sets_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> ovf_flag);
endmodule

// File: rtl/tca_unit.sv
module tca_unit
    import tca_pkg::*;
#(
    parameter int CW      = 16,
    parameter bit IS_WDOG = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          step,
    input  logic          lo_wrap,
    input  logic          pin_in,
    input  logic          wr_cmp_lo,
    input  logic          wr_cmp_hi,
    input  logic          wr_mode,
    input  logic [7:0]    wr_data,
    input  logic          evt_clr,
    output logic          pin_out,
    output logic          evt_flag,
    output logic          wdt_req,
    output logic [CW-1:0] cmp_val
);
    localparam int HW = CW - 8;

    typedef struct packed {
        mode_e         mode;
        logic [CW-1:0] cmp;
        logic          s1;
        logic          s2;
        logic          prev;
        logic          pin;
        logic          flag;
        logic          wdt;
    } unit_state_t;

    unit_state_t q, d;
    logic        rise, fall, hit, cap;

    always_comb begin
        d      = q;
        d.s1   = pin_in;
        d.s2   = q.s1;
        d.prev = q.s2;
        d.wdt  = 1'b0;
        rise   = q.s2 & ~q.prev;
        fall   = ~q.s2 & q.prev;
        hit    = step && (count == q.cmp);
        cap    = 1'b0;
        if (evt_clr)
            d.flag = 1'b0;
        unique case (q.mode)
            MD_CAP_RISE, MD_CAP_FALL, MD_CAP_BOTH: begin
                cap   = (rise & q.mode[0]) | (fall & q.mode[1]);
                d.pin = 1'b0;
                if (cap) begin
                    d.cmp  = count;
                    d.flag = 1'b1;
                end
            end
            MD_TIMER: begin
                d.pin = 1'b0;
                if (hit) d.flag = 1'b1;
            end
            MD_TOGGLE: begin
                if (hit) begin
                    d.pin  = ~q.pin;
                    d.flag = 1'b1;
                end
            end
            MD_PWM: begin
                d.pin = (count[7:0] < q.cmp[7:0]);
                if (lo_wrap)
                    d.cmp[7:0] = q.cmp[CW-1:CW-8];
            end
            MD_WDOG: begin
                d.pin = 1'b0;
                d.wdt = IS_WDOG && hit;
            end
            default: d.pin = 1'b0;
        endcase
        if (wr_cmp_lo)
            d.cmp[7:0] = wr_data;
        if (wr_cmp_hi)
            d.cmp[CW-1:8] = HW'(wr_data);
        if (wr_mode)
            d.mode = mode_e'(wr_data[2:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pin_out  = q.pin;
    assign evt_flag = q.flag;
    assign wdt_req  = q.wdt;
    assign cmp_val  = q.cmp;

    // R12: event flag is sticky until its clear strobe
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !evt_clr) |=> evt_flag);

    // R10: reset request lasts a single clock
    p_wdt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |=> !wdt_req);

    // R8: low byte at or above the compare byte yields a low pin
    p_pwm_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MD_PWM && $past(q.mode == MD_PWM) &&
         $past(count[7:0] >= q.cmp[7:0])) |-> !pin_out);
endmodule

// File: rtl/tca_top.sv
module tca_top
    import tca_pkg::*;
#(
    parameter int NUM_MOD = 5,
    parameter int CW      = 16,
    localparam int IW     = $clog2(NUM_MOD)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic [1:0]            clk_src,
    input  logic                  ext_clk,
    input  logic                  t0_tick,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [NUM_MOD-1:0]    evt_clr,
    input  logic                  ovf_clr,
    input  logic [NUM_MOD-1:0]    pin_in,
    output logic [NUM_MOD-1:0]    pin_out,
    output logic [NUM_MOD-1:0]    evt_flag,
    output logic                  ovf_flag,
    output logic                  wdt_rst,
    output logic [CW-1:0]         tb_value,
    output logic [NUM_MOD*CW-1:0] mod_reg
);
    logic [CW-1:0]      count;
    logic               step, lo_wrap;
    logic [NUM_MOD-1:0] wdt_req;
    logic               wr_tb_lo, wr_tb_hi;

    assign wr_tb_lo = wr_en && (wsel_e'(wr_sel) == WR_TB_LO);
    assign wr_tb_hi = wr_en && (wsel_e'(wr_sel) == WR_TB_HI);

    tca_timebase #(.CW(CW)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .src_sel  (clk_src),
        .ext_clk  (ext_clk),
        .t0_tick  (t0_tick),
        .wr_lo    (wr_tb_lo),
        .wr_hi    (wr_tb_hi),
        .wr_data  (wr_data),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .step     (step),
        .lo_wrap  (lo_wrap),
        .ovf_flag (ovf_flag)
    );

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_unit
        logic sel;
        assign sel = wr_en && (wr_idx == IW'(i));
        tca_unit #(.CW(CW), .IS_WDOG(i == NUM_MOD - 1)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (count),
            .step      (step),
            .lo_wrap   (lo_wrap),
            .pin_in    (pin_in[i]),
            .wr_cmp_lo (sel && (wsel_e'(wr_sel) == WR_CMP_LO)),
            .wr_cmp_hi (sel && (wsel_e'(wr_sel) == WR_CMP_HI)),
            .wr_mode   (sel && (wsel_e'(wr_sel) == WR_MODE)),
            .wr_data   (wr_data),
            .evt_clr   (evt_clr[i]),
            .pin_out   (pin_out[i]),
            .evt_flag  (evt_flag[i]),
            .wdt_req   (wdt_req[i]),
            .cmp_val   (mod_reg[i*CW +: CW])
        );
    end

    assign wdt_rst  = |wdt_req;
    assign tb_value = count;

    // R10: only the last channel may request a reset
    p_wdt_last_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req[NUM_MOD-2:0] == '0);
endmodule

// File: tb/tb_tca_top.sv
`timescale 1ns/1ps
module tb_tca_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [1:0]  clk_src = 2'd2;
    logic        ext_clk = 1'b0;
    logic        t0_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [2:0]  wr_idx = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [4:0]  evt_clr = 5'd0;
    logic        ovf_clr = 1'b0;
    logic [4:0]  pin_in = 5'd0;
    logic [4:0]  pin_out, evt_flag;
    logic        ovf_flag, wdt_rst;
    logic [15:0] tb_value;
    logic [79:0] mod_reg;

    int n_cmp = 0;
    int n_bad = 0;
    int wdt_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tca_top dut (.*);

    always @(negedge clk) if (wdt_rst) wdt_cnt++;

    typedef struct packed {
        logic [2:0]  idx;
        logic [2:0]  mode;
        logic [15:0] cmp;
        logic [15:0] start;
        logic [7:0]  steps;
        logic        exp_flag;
        logic        exp_pin;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 3'd4, 16'h0010, 16'h000C, 8'd4, 1'b1, 1'b0},
        '{3'd1, 3'd4, 16'h0010, 16'h000C, 8'd3, 1'b0, 1'b0},
        '{3'd2, 3'd5, 16'h1234, 16'h1230, 8'd5, 1'b1, 1'b1},
        '{3'd3, 3'd5, 16'h00FF, 16'h00F0, 8'd4, 1'b0, 1'b0},
        '{3'd4, 3'd4, 16'h0100, 16'h00FE, 8'd2, 1'b1, 1'b0},
        '{3'd0, 3'd5, 16'h0005, 16'h0005, 8'd3, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [2:0] i, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_tb(input logic [15:0] v);
        wr(3'd0, 3'd0, v[7:0]);
        wr(3'd1, 3'd0, v[15:8]);
    endtask

    task automatic set_cmp(input logic [2:0] i, input logic [15:0] v);
        wr(3'd2, i, v[7:0]);
        wr(3'd3, i, v[15:8]);
    endtask

    task automatic set_mode(input logic [2:0] i, input logic [2:0] m);
        wr(3'd4, i, {5'd0, m});
    endtask

    task automatic step1();
        @(negedge clk); t0_tick = 1'b1;
        @(negedge clk); t0_tick = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_flags();
        @(negedge clk); evt_clr = 5'h1F;
        @(negedge clk); evt_clr = 5'h00;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", tb_value, 16'h0);
        chk("R1 regs", mod_reg == '0, 1);
        chk("R1 pins", pin_out, 5'h0);
        chk("R1 flags", {evt_flag, ovf_flag, wdt_rst}, 7'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: write codes address channel registers
        set_cmp(3'd3, 16'hBEEF);
        chk("R11 cmp ch3", mod_reg[3*16 +: 16], 16'hBEEF);
        chk("R11 ch2 untouched", mod_reg[2*16 +: 16], 16'h0000);
        set_tb(16'hA55A);
        chk("R11 count write", tb_value, 16'hA55A);

        // R2 tick source (code 2), R6, R7: vector table
        clk_src = 2'd2;
        run_en  = 1'b1;
        for (int v = 0; v < 6; v++) begin
            set_tb(VEC[v].start);
            set_cmp(VEC[v].idx, VEC[v].cmp);
            set_mode(VEC[v].idx, VEC[v].mode);
            clr_flags();
            for (int s = 0; s < int'(VEC[v].steps); s++) step1();
            settle();
            chk($sformatf("R2 vec%0d count", v), tb_value, VEC[v].start + 16'(VEC[v].steps));
            chk($sformatf("R6/R7 vec%0d flag", v), evt_flag[VEC[v].idx], VEC[v].exp_flag);
            chk($sformatf("R6/R7 vec%0d pin", v), pin_out[VEC[v].idx], VEC[v].exp_pin);
            set_mode(VEC[v].idx, 3'd0);
        end

        // R12: flag clear
        set_tb(16'h0020); set_cmp(3'd1, 16'h0021); set_mode(3'd1, 3'd4);
        clr_flags(); step1(); settle();
        chk("R12 flag set", evt_flag[1], 1'b1);
        repeat (3) @(negedge clk);
        chk("R12 flag sticky", evt_flag[1], 1'b1);
        @(negedge clk); evt_clr = 5'b00010;
        @(negedge clk); evt_clr = 5'b00000;
        chk("R12 flag cleared", evt_flag[1], 1'b0);
        set_mode(3'd1, 3'd0);

        // R2/R3: divide-by-2 and divide-by-4
        @(negedge clk); run_en = 1'b0;
        set_tb(16'h0000);
        @(negedge clk); clk_src = 2'd0; run_en = 1'b1;
        repeat (20) @(negedge clk);
        run_en = 1'b0;
        chk("R2 div2", tb_value, 16'd10);
        repeat (5) @(negedge clk);
        chk("R3 hold", tb_value, 16'd10);
        set_tb(16'h0000);
        @(negedge clk); clk_src = 2'd1; run_en = 1'b1;
        repeat (20) @(negedge clk);
        run_en = 1'b0;
        chk("R2 div4", tb_value, 16'd5);

        // R2: external clock pin
        set_tb(16'h0000);
        @(negedge clk); clk_src = 2'd3; run_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        chk("R2 ext", tb_value, 16'd3);
        clk_src = 2'd2;

        // R4: overflow
        set_tb(16'hFFFF); step1(); settle();
        chk("R4 wrap count", tb_value, 16'h0000);
        chk("R4 ovf set", ovf_flag, 1'b1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R4 ovf cleared", ovf_flag, 1'b0);
        set_tb(16'hFFFF);
        @(negedge clk); t0_tick = 1'b1; ovf_clr = 1'b1;
        @(negedge clk); t0_tick = 1'b0; ovf_clr = 1'b0;
        chk("R4 set beats clear", ovf_flag, 1'b1);

        // R5: capture (no ticks, count static)
        set_mode(3'd1, 3'd1); set_tb(16'h0ABC); clr_flags();
        @(negedge clk); pin_in[1] = 1'b1; repeat (4) @(negedge clk);
        chk("R5 rise capture", mod_reg[1*16 +: 16], 16'h0ABC);
        chk("R5 rise flag", evt_flag[1], 1'b1);
        clr_flags(); set_tb(16'h0DEF);
        @(negedge clk); pin_in[1] = 1'b0; repeat (4) @(negedge clk);
        chk("R5 fall ignored", mod_reg[1*16 +: 16], 16'h0ABC);
        chk("R5 fall no flag", evt_flag[1], 1'b0);
        chk("R5 pin low", pin_out[1], 1'b0);
        set_mode(3'd1, 3'd3); set_tb(16'h0777);
        @(negedge clk); pin_in[1] = 1'b1; repeat (4) @(negedge clk);
        chk("R5 both rise", mod_reg[1*16 +: 16], 16'h0777);
        set_tb(16'h0888);
        @(negedge clk); pin_in[1] = 1'b0; repeat (4) @(negedge clk);
        chk("R5 both fall", mod_reg[1*16 +: 16], 16'h0888);
        set_mode(3'd2, 3'd2); set_cmp(3'd2, 16'h0000); set_tb(16'h0123);
        @(negedge clk); pin_in[2] = 1'b1; repeat (4) @(negedge clk);
        chk("R5 fallmode rise ignored", mod_reg[2*16 +: 16], 16'h0000);
        set_tb(16'h0456);
        @(negedge clk); pin_in[2] = 1'b0; repeat (4) @(negedge clk);
        chk("R5 fallmode capture", mod_reg[2*16 +: 16], 16'h0456);
        set_mode(3'd1, 3'd0); set_mode(3'd2, 3'd0);

        // R8/R9: PWM on channel 0
        set_cmp(3'd0, 16'h8010); set_mode(3'd0, 3'd6);
        set_tb(16'h0005); settle();
        chk("R8 below", pin_out[0], 1'b1);
        set_tb(16'h0010); settle();
        chk("R8 equal low", pin_out[0], 1'b0);
        set_tb(16'h0020); settle();
        chk("R8 above", pin_out[0], 1'b0);
        set_tb(16'h00FF); step1(); settle();
        chk("R9 reload", mod_reg[15:0], 16'h8080);
        chk("R9 pin after reload", pin_out[0], 1'b1);
        set_mode(3'd0, 3'd0);

        // R10: watchdog
        set_cmp(3'd4, 16'h0003); set_mode(3'd4, 3'd7); clr_flags();
        set_tb(16'h0002); wdt_cnt = 0; step1(); settle();
        chk("R10 wdt pulse", wdt_cnt, 1);
        chk("R10 no flag", evt_flag[4], 1'b0);
        set_tb(16'h0002); wdt_cnt = 0;
        set_cmp(3'd4, 16'h0100); step1(); settle();
        chk("R10 rewrite avoids", wdt_cnt, 0);
        set_mode(3'd4, 3'd0);
        set_cmp(3'd0, 16'h0003); set_mode(3'd0, 3'd7);
        set_tb(16'h0002); wdt_cnt = 0; step1(); settle();
        chk("R10 ch0 no wdt", wdt_cnt, 0);

        done = 1'b1;
        report();
    end
endmodule